// File: doc/BRIEF.md
# BCD Real-Time Clock with Field Stepping

This block keeps calendar time in packed BCD: seconds, minutes, hours, day of week, day of month, month and a two-digit year. It counts from a tick strobe that pulses once per period of a 32768 Hz reference (`tickIn`, sampled on the system clock). A free-running divider turns those ticks into a one-second advance and into a square wave on `irqWave` that software or an interrupt controller can watch.

A small control word holds a pause flag and a three-bit field selector. While the clock is paused, each pulse on `adjWe` steps the selected field up by one. The step wraps inside that field's own range and never carries into a neighbour. Pausing also speeds the square wave up by a factor of 2^FAST_LOG2 (4096 with the defaults), so software can tell a paused clock from a running one. The two read words are always live.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the clock reads 00:00:00, day of week 6, day 01, month 01, year 99. It is running, and the selector holds code 7.
- R2: `timeWord` holds BCD seconds 00-59 in bits 7:0, BCD minutes 00-59 in bits 15:8, BCD hours 00-23 in bits 23:16 and day of week 1-7 in bits 31:24.
- R3: `dateWord` holds BCD day 01-31 in bits 7:0, BCD month 01-12 in bits 15:8 (bits 15:13 always 0), BCD year 00-99 in bits 23:16, and zero in bits 31:24.
- R4: While running, every 2^DIV_BITS `tickIn` pulses advance seconds by one. The carry ripples 59→00 into minutes, 59→00 into hours, and 23→00 into the day.
- R5: The day wraps to 01 after the month's last day. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the BCD year's value is divisible by 4 and 28 otherwise. All other months have 31 days.
- R6: Each day rollover advances the day of week, which wraps 7→1. A wrap of month 12→01 increments the year, and year 99 wraps to 00.
- R7: A `ctrlWe` write loads `ctrlData`. Bit 0 is the pause flag: 1 stops the one-second advance. Bits 3:1 select the field: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day, 5 month, 6 year, 7 none.
- R8: While paused, each `adjWe` pulse increments the selected field by one with no carry. The wraps are: seconds and minutes 59→00, hours 23→00, day of week 7→1, day from the current month's last day to 01, month 12→01, year 99→00.
- R9: An `adjWe` pulse has no effect while the clock is running or while code 7 is selected.
- R10: When `ctrlWe` and `adjWe` fall in the same cycle, the step uses the control value held before that write.
- R11: `irqWave` is a 50 % square wave built from the divider. While running, its period is 2^DIV_BITS ticks. While paused, its period is 2^(DIV_BITS-FAST_LOG2) ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle strobe per reference-clock period |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlData | input | 4 | Control word: bit 0 pause, bits 3:1 field select |
| adjWe | input | 1 | Adjust strobe; steps the selected field |
| timeWord | output | 32 | Packed BCD time and day of week |
| dateWord | output | 32 | Packed BCD day, month and year |
| irqWave | output | 1 | Square-wave interrupt line |

## Verification
A control write and an adjust pulse can arrive in the same cycle. The bench provokes this by holding the clock paused with seconds selected, then in one cycle writing a control word that selects minutes while also pulsing `adjWe`. The scoreboard expects the seconds field to step and the minutes field to stay put, and a following lone adjust pulse to step minutes. A second-tick carry and a control write that pauses cannot collide in the bench, because it always pauses a few cycles after an observed tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [2:0] SEL_SEC   = 3'd0;
  localparam logic [2:0] SEL_MIN   = 3'd1;
  localparam logic [2:0] SEL_HOUR  = 3'd2;
  localparam logic [2:0] SEL_DOW   = 3'd3;
  localparam logic [2:0] SEL_DAY   = 3'd4;
  localparam logic [2:0] SEL_MONTH = 3'd5;
  localparam logic [2:0] SEL_YEAR  = 3'd6;
  localparam logic [2:0] SEL_NONE  = 3'd7;

  // Strobes from control to the field datapath
  typedef struct packed {
    logic       secTick;  // one-second advance
    logic       adjStep;  // qualified adjust step
    logic [2:0] adjSel;   // field to step
  } rtcStrobe_t;

  // BCD increment with wrap; a value at or past hi wraps to lo
  function automatic logic [7:0] bcdStep(input logic [7:0] v,
                                         input logic [7:0] lo,
                                         input logic [7:0] hi);
    if (v >= hi)              return lo;
    else if (v[3:0] == 4'd9)  return {v[7:4] + 4'd1, 4'd0};
    else                      return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last BCD day of a BCD month, leap year when year value % 4 == 0
  function automatic logic [7:0] monthLast(input logic [7:0] mon,
                                           input logic [7:0] yr);
    logic [6:0] yb;
    yb = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DIV_BITS  = 15,
  parameter int FAST_LOG2 = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       ctrlWe,
  input  logic [3:0] ctrlData,
  input  logic       adjWe,
  output rtcStrobe_t strb,
  output logic       irqWave
);

  localparam int SLOW_BIT = DIV_BITS - 1;
  localparam int FAST_BIT = DIV_BITS - 1 - FAST_LOG2;

  logic                pauseR;
  logic [2:0]          selR;
  logic [DIV_BITS-1:0] divCnt;
  logic                divWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseR <= 1'b0;
      selR   <= SEL_NONE;
      divCnt <= '0;
    end else begin
      if (ctrlWe) begin
        pauseR <= ctrlData[0];
        selR   <= ctrlData[3:1];
      end
      if (tickIn) divCnt <= divCnt + 1'b1;
    end
  end

  assign divWrap = &divCnt;

  // Registered control value is used, so a same-cycle write affects later cycles
  always_comb begin
    strb.secTick = tickIn && !pauseR && divWrap;
    strb.adjStep = adjWe && pauseR && (selR != SEL_NONE);
    strb.adjSel  = selR;
  end

  generate
    if (FAST_BIT >= 0) begin : g_wave
      assign irqWave = pauseR ? divCnt[FAST_BIT] : divCnt[SLOW_BIT];
    end else begin : g_wave_slow_only
      assign irqWave = divCnt[SLOW_BIT];
    end
  endgenerate

  // R11: the wave only moves on a tick or a mode change
  p_wave_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn && !ctrlWe) |=> $stable(irqWave));

  // R4: two second advances are never back to back
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.secTick |=> !strb.secTick);

endmodule

// File: rtl/rtc_fields.sv
module rtc_fields
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  rtcStrobe_t  strb,
  output logic [31:0] timeWord,
  output logic [31:0] dateWord
);

  logic [7:0] secR, minR, hourR, dowR, dayR, monR, yearR;
  logic [7:0] lastDay;
  logic       minAdv, hourAdv, dayAdv, monAdv, yearAdv;
  logic [6:0] stepHit;

  always_comb begin
    lastDay = monthLast(monR, yearR);
    minAdv  = strb.secTick && (secR  == 8'h59);
    hourAdv = minAdv       && (minR  == 8'h59);
    dayAdv  = hourAdv      && (hourR == 8'h23);
    monAdv  = dayAdv       && (dayR  >= lastDay);
    yearAdv = monAdv       && (monR  == 8'h12);
  end

  genvar gi;
  generate
    for (gi = 0; gi < 7; gi++) begin : g_hit
      assign stepHit[gi] = strb.adjStep && (strb.adjSel == 3'(gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secR  <= 8'h00;
      minR  <= 8'h00;
      hourR <= 8'h00;
      dowR  <= 8'h06;
      dayR  <= 8'h01;
      monR  <= 8'h01;
      yearR <= 8'h99;
    end else begin
      if (strb.secTick || stepHit[SEL_SEC])   secR  <= bcdStep(secR,  8'h00, 8'h59);
      if (minAdv  || stepHit[SEL_MIN])        minR  <= bcdStep(minR,  8'h00, 8'h59);
      if (hourAdv || stepHit[SEL_HOUR])       hourR <= bcdStep(hourR, 8'h00, 8'h23);
      if (dayAdv  || stepHit[SEL_DOW])        dowR  <= bcdStep(dowR,  8'h01, 8'h07);
      if (dayAdv  || stepHit[SEL_DAY])        dayR  <= bcdStep(dayR,  8'h01, lastDay);
      if (monAdv  || stepHit[SEL_MONTH])      monR  <= bcdStep(monR,  8'h01, 8'h12);
      if (yearAdv || stepHit[SEL_YEAR])       yearR <= bcdStep(yearR, 8'h00, 8'h99);
    end
  end

  assign timeWord = {dowR, hourR, minR, secR};
  assign dateWord = {8'h00, yearR, monR, dayR};

  // R2: time fields stay in legal BCD ranges
  p_time_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (secR <= 8'h59) && (secR[3:0] <= 4'd9) && (minR <= 8'h59) && (minR[3:0] <= 4'd9)
    && (hourR <= 8'h23) && (hourR[3:0] <= 4'd9) && (dowR >= 8'h01) && (dowR <= 8'h07));

  // R3: date fields stay in legal BCD ranges
  p_date_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dayR >= 8'h01) && (dayR <= 8'h31) && (dayR[3:0] <= 4'd9)
    && (monR >= 8'h01) && (monR <= 8'h12) && (yearR[3:0] <= 4'd9) && (yearR <= 8'h99));

  // R9: without a strobe nothing moves
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.secTick && !strb.adjStep) |=> ($stable(timeWord) && $stable(dateWord)));

  // R8: stepping seconds never carries into minutes
  p_adj_no_carry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adjStep && strb.adjSel == SEL_SEC) |=> $stable(minR));

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int DIV_BITS  = 15,
  parameter int FAST_LOG2 = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic        ctrlWe,
  input  logic [3:0]  ctrlData,
  input  logic        adjWe,
  output logic [31:0] timeWord,
  output logic [31:0] dateWord,
  output logic        irqWave
);

  rtcStrobe_t strb;

  rtc_ctrl #(.DIV_BITS(DIV_BITS), .FAST_LOG2(FAST_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .ctrlWe(ctrlWe),
    .ctrlData(ctrlData), .adjWe(adjWe), .strb(strb), .irqWave(irqWave)
  );

  rtc_fields u_fields (
    .clk(clk), .rstN(rstN), .strb(strb),
    .timeWord(timeWord), .dateWord(dateWord)
  );

endmodule

// File: tb/bcd_rtc_tb.sv
`timescale 1ns/1ps
module bcd_rtc_tb;

  localparam int DIV_BITS  = 6;
  localparam int FAST_LOG2 = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [3:0]  ctrlData = 4'h0;
  logic        adjWe = 1'b0;
  logic [31:0] timeWord, dateWord;
  logic        irqWave;

  always #2.5 clk = ~clk;

  bcd_rtc #(.DIV_BITS(DIV_BITS), .FAST_LOG2(FAST_LOG2)) u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .adjWe(adjWe), .timeWord(timeWord), .dateWord(dateWord), .irqWave(irqWave)
  );

  int nChk = 0, nBad = 0;
  bit done = 0, monOn = 0;
  logic [63:0] expQ[$];
  string       tagQ[$];
  logic [63:0] lastSeen;

  // reference model
  int s = 0, mi = 0, h = 0, dw = 6, d = 1, mo = 1, y = 99;
  bit mPause = 0;
  int mSel = 7;

  function automatic logic [7:0] toB(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int lastOf(int m, int yy);
    if (m == 2) return (yy % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic logic [63:0] modelWord();
    return {toB(dw), toB(h), toB(mi), toB(s), 8'h00, toB(y), toB(mo), toB(d)};
  endfunction
  function automatic int getF(int sel);
    case (sel)
      0: return s; 1: return mi; 2: return h; 3: return dw;
      4: return d; 5: return mo; default: return y;
    endcase
  endfunction

  task automatic applyAdj(int sel);
    case (sel)
      0: s  = (s + 1) % 60;
      1: mi = (mi + 1) % 60;
      2: h  = (h + 1) % 24;
      3: dw = (dw == 7) ? 1 : dw + 1;
      4: d  = (d >= lastOf(mo, y)) ? 1 : d + 1;
      5: mo = (mo == 12) ? 1 : mo + 1;
      default: y = (y + 1) % 100;
    endcase
  endtask

  task automatic advance();
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0;
          dw = (dw == 7) ? 1 : dw + 1;
          if (d >= lastOf(mo, y)) begin
            d = 1;
            if (mo == 12) begin mo = 1; y = (y + 1) % 100; end
            else mo++;
          end else d++;
        end
      end
    end
  endtask

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushExp(string tag);
    expQ.push_back(modelWord());
    tagQ.push_back(tag);
  endtask

  // monitor: pop an expected item on every observed change
  always @(negedge clk) begin
    if (monOn && rstN) begin
      logic [63:0] cur;
      cur = {timeWord, dateWord};
      if (cur !== lastSeen) begin
        if (expQ.size() == 0) chk(1'b0, "unexpected change R9", cur, lastSeen);
        else begin
          logic [63:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(cur === e, t, cur, e);
        end
        lastSeen = cur;
      end
    end
  end

  task automatic writeCtrl(bit p, int sel);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlData = {3'(sel), p};
    @(negedge clk);
    ctrlWe = 1'b0;
    mPause = p; mSel = sel;
  endtask

  task automatic adjust(string tag);
    @(negedge clk);
    adjWe = 1'b1;
    if (mPause && mSel != 7) begin applyAdj(mSel); pushExp(tag); end
    @(negedge clk);
    adjWe = 1'b0;
  endtask

  task automatic setField(int sel, int target, string tag);
    writeCtrl(1'b1, sel);
    while (getF(sel) != target) adjust(tag);
  endtask

  task automatic drainWait(string tag);
    int n = 0;
    while (expQ.size() != 0 && n < 300) begin @(negedge clk); n++; end
    chk(expQ.size() == 0, tag, 64'(expQ.size()), 64'd0);
  endtask

  task automatic runOneSecond(string tag);
    advance();
    pushExp(tag);
    writeCtrl(1'b0, mSel);
    drainWait(tag);
    writeCtrl(1'b1, mSel);
  endtask

  task automatic setMoment(int yy, int mm, int dd, int hh, int mn, int ss, string tag);
    setField(6, yy, tag); setField(5, mm, tag); setField(4, dd, tag);
    setField(2, hh, tag); setField(1, mn, tag); setField(0, ss, tag);
  endtask

  task automatic checkNow(string tag);
    repeat (3) @(negedge clk);
    chk(({timeWord, dateWord} === modelWord()) && (expQ.size() == 0), tag,
        {timeWord, dateWord}, modelWord());
  endtask

  task automatic measureWave(int expHigh, int expRise, string tag);
    int highs = 0, rises = 0;
    logic prev;
    @(negedge clk);
    prev = irqWave;
    for (int i = 0; i < 64; i++) begin
      if (prev) highs++;
      @(negedge clk);
      if (irqWave && !prev) rises++;
      prev = irqWave;
    end
    chk(highs == expHigh, {tag, " high count"}, 64'(highs), 64'(expHigh));
    chk(rises == expRise, {tag, " rising edges"}, 64'(rises), 64'(expRise));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tickIn = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(timeWord === 32'h0600_0000, "R1 reset time", 64'(timeWord), 64'h0600_0000);
    chk(dateWord === 32'h0099_0101, "R1 reset date", 64'(dateWord), 64'h0099_0101);
    lastSeen = {timeWord, dateWord};
    monOn = 1;
    writeCtrl(1'b1, 7);

    // R8 per-field wraps without carry (also checks R2/R3 packing)
    setField(0, 59, "R2 seconds step"); adjust("R8 seconds 59->00");
    setField(1, 59, "R2 minutes step"); adjust("R8 minutes 59->00");
    setField(2, 23, "R2 hours step");   adjust("R8 hours 23->00");
    writeCtrl(1'b1, 3); adjust("R8 dow 6->7"); adjust("R8 dow 7->1");
    setField(5, 12, "R3 month step");   adjust("R8 month 12->01");
    writeCtrl(1'b1, 6); adjust("R8 year 99->00");
    setField(4, 31, "R3 day step");     adjust("R8 day 31->01");

    // R9 code 7 ignores adjust
    writeCtrl(1'b1, 7); adjust("R9"); checkNow("R9 select 7 ignored");

    // R10 same-cycle control write and adjust
    writeCtrl(1'b1, 0);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlData = {3'd1, 1'b1}; adjWe = 1'b1;
    applyAdj(0); pushExp("R10 old select steps seconds");
    @(negedge clk);
    ctrlWe = 1'b0; adjWe = 1'b0; mSel = 1;
    adjust("R10 new select steps minutes");
    drainWait("R10");

    // R7 paused clock holds
    repeat (200) @(negedge clk);
    checkNow("R7 pause freezes");

    // R4 plain count and minute carry
    setMoment(20, 6, 15, 10, 0, 0, "R4 setup");
    runOneSecond("R4 second advance");
    setField(0, 59, "R4 setup");
    runOneSecond("R4 minute carry");

    // R9 adjust while running is ignored
    advance(); pushExp("R4 running");
    writeCtrl(1'b0, 0);
    drainWait("R4 running");
    adjust("R9");
    writeCtrl(1'b1, 0);
    checkNow("R9 running adjust ignored");

    // R5 month lengths and leap
    setMoment(3, 2, 28, 23, 59, 59, "R5 setup");
    runOneSecond("R5 non-leap Feb 28 -> Mar 01");
    setMoment(4, 2, 28, 23, 59, 59, "R5 setup");
    runOneSecond("R5 leap Feb 28 -> Feb 29");
    setMoment(4, 2, 29, 23, 59, 59, "R5 setup");
    runOneSecond("R5 leap Feb 29 -> Mar 01");
    setMoment(4, 4, 30, 23, 59, 59, "R5 setup");
    runOneSecond("R5 Apr 30 -> May 01");

    // R6 year wrap and day-of-week wrap
    setMoment(99, 12, 31, 23, 59, 59, "R6 setup");
    writeCtrl(1'b1, 3);
    while (dw != 7) adjust("R6 setup");
    runOneSecond("R6 year 99->00 dow 7->1");
    chk(dateWord[31:24] == 8'h00 && dateWord[15:13] == 3'd0, "R3 zero bits",
        64'(dateWord), 64'(modelWord()));

    // R11 waves
    measureWave(32, 8, "R11 paused wave");
    advance(); pushExp("R11 running tick");
    writeCtrl(1'b0, 0);
    measureWave(32, 1, "R11 running wave");
    drainWait("R11 running tick");
    monOn = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule